// File: doc/BRIEF.md
# SPI Status Flag Controller

This block keeps the three status flags of an 8-bit SPI peripheral: transfer finished, write collision and mode fault. It decides when each flag is raised and when it may drop again. A small CPU-side register bus reaches the block through a register select code and separate read and write strobes. The shift engine supplies a busy level, a one-cycle done pulse and the level seen on the slave-select pin. The master-mode bit, a bit that turns the slave-select pin into an output, and an interrupt enable come from the control logic.

A flag never drops on a single access. Software must first read the status register while the flag is 1, which arms that flag. A later access of a specific kind then clears it. For the transfer and collision flags that access is a read or write of the data register. For the mode-fault flag it is a write to control register 1. When the data register is written during a transfer, the write is reported as blocked so the shifter keeps its byte, and the collision flag is raised. The interrupt request combines the transfer and mode-fault flags with the enable. The collision flag never requests an interrupt.

Top module: `spi_status_flags`

## Requirements
- R1: While `rst` is high at a clock edge, all three flags, every arm bit and `irq` are 0, and `stat_rdata` is 8'h00 after that edge.
- R2: `stat_rdata` carries the transfer flag at bit 7, the collision flag at bit 6 and the mode-fault flag at bit 4, and 0 at every other bit. A write with `reg_sel`=0 (status register) changes no flag.
- R3: A cycle with `xfer_done`=1 makes `xfer_flag` 1 after the next clock edge.
- R4: `xfer_flag` clears at the edge of a data access (`reg_sel`=1 with `rd_stb` or `wr_stb`) only if an earlier cycle read the status register (`reg_sel`=0, `rd_stb`) while the flag was 1. A status read that sees the flag at 0 arms nothing, and no other access clears the flag.
- R5: A write with `reg_sel`=1 while `xfer_busy`=1 drives `data_wr_blocked` high in that same cycle and makes `wcol_flag` 1 after the edge.
- R6: `wcol_flag` clears by the same two steps as R4 and never contributes to `irq`.
- R7: With `master_mode`=1, `ss_pin_out`=0 and `ss_level`=0 in a cycle, `modf_flag` is 1 after the edge.
- R8: With `ss_pin_out`=1 in a cycle, `modf_flag` is 0 after the edge and its arm bit is dropped, whatever the slave-select level is.
- R9: `modf_flag` clears at the edge of a write with `reg_sel`=2 (control register 1) only if an earlier status read saw it at 1. Data accesses and reads of control register 1 do not clear it.
- R10: When a set condition and the completing clear access fall in the same cycle, the flag stays 1.
- R11: `irq` is registered and equals `irq_en` AND (`xfer_flag` OR `modf_flag`) as they stand after the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 status, 1 data, 2 control 1, 3 none |
| rd_stb | input | 1 | CPU read strobe for the selected register |
| wr_stb | input | 1 | CPU write strobe for the selected register |
| xfer_busy | input | 1 | Shift engine has a transfer in progress |
| xfer_done | input | 1 | One-cycle pulse at the end of the eighth clock of a transfer |
| ss_level | input | 1 | Level on the slave-select pin (0 = asserted) |
| master_mode | input | 1 | Peripheral configured as master |
| ss_pin_out | input | 1 | Slave-select pin used as an output |
| irq_en | input | 1 | Interrupt enable |
| stat_rdata | output | 8 | Status register read value |
| xfer_flag | output | 1 | Transfer finished flag |
| wcol_flag | output | 1 | Write collision flag |
| modf_flag | output | 1 | Mode fault flag |
| data_wr_blocked | output | 1 | Current data write is discarded |
| irq | output | 1 | Interrupt request |

## Verification
A wrong arm bit never appears on the ports by itself. It shows only when the second access of a clear sequence arrives: a flag that drops without a prior status read, or one that stays up after a correct sequence. That difference is visible one edge after the access. The bench therefore sweeps every combination of the optional status read, each kind of second access, and a coinciding set event, for each flag. A wrongly decoded set condition or priority shows on the flag outputs and on `irq` one edge after the event.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    REG_STATUS = 2'd0,
    REG_DATA   = 2'd1,
    REG_CTRL1  = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
  localparam int NFLAG  = 3;
  localparam int F_XFER = 0;
  localparam int F_WCOL = 1;
  localparam int F_MODF = 2;
endpackage

// File: rtl/spi_stat_decode.sv
module spi_stat_decode
  import spi_stat_pkg::*;
#(
  parameter int NF = NFLAG
) (
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic             xfer_busy,
  input  logic             xfer_done,
  input  logic             ss_level,
  input  logic             master_mode,
  input  logic             ss_pin_out,
  output logic [NF-1:0]    set_vec,
  output logic [NF-1:0]    clr_vec,
  output logic [NF-1:0]    force_vec,
  output logic             stat_rd,
  output logic             wr_blocked
);
  logic data_acc, data_wr, ctrl_wr;

  always_comb begin
    stat_rd    = rd_stb && (reg_sel == REG_STATUS);
    data_acc   = (rd_stb || wr_stb) && (reg_sel == REG_DATA);
    data_wr    = wr_stb && (reg_sel == REG_DATA);
    ctrl_wr    = wr_stb && (reg_sel == REG_CTRL1);
    wr_blocked = data_wr && xfer_busy;

    set_vec   = '0;
    clr_vec   = '0;
    force_vec = '0;

    set_vec[F_XFER] = xfer_done;
    clr_vec[F_XFER] = data_acc;

    set_vec[F_WCOL] = wr_blocked;
    clr_vec[F_WCOL] = data_acc;

    // detection is off while the pin drives out
    set_vec[F_MODF]   = master_mode && !ss_level && !ss_pin_out;
    clr_vec[F_MODF]   = ctrl_wr;
    force_vec[F_MODF] = ss_pin_out;
  end
endmodule

// File: rtl/spi_stat_flag_cell.sv
module spi_stat_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic arm_ev,
  input  logic clr_acc,
  input  logic force_clr,
  output logic flag_q,
  output logic flag_nx
);
  logic armed_q, armed_nx;
  logic clr_hit;

  always_comb begin
    clr_hit  = armed_q && clr_acc;
    flag_nx  = flag_q;
    armed_nx = armed_q;
    if (force_clr || clr_hit) begin
      flag_nx  = 1'b0;
      armed_nx = 1'b0;
    end else if (arm_ev && flag_q) begin
      armed_nx = 1'b1;
    end
    // a new event wins over the clearing access
    if (set_ev) flag_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_nx;
      armed_q <= armed_nx;
    end
  end
endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags
  import spi_stat_pkg::*;
#(
  parameter int STAT_W   = 8,
  parameter int XFER_BIT = 7,
  parameter int WCOL_BIT = 6,
  parameter int MODF_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              xfer_busy,
  input  logic              xfer_done,
  input  logic              ss_level,
  input  logic              master_mode,
  input  logic              ss_pin_out,
  input  logic              irq_en,
  output logic [STAT_W-1:0] stat_rdata,
  output logic              xfer_flag,
  output logic              wcol_flag,
  output logic              modf_flag,
  output logic              data_wr_blocked,
  output logic              irq
);
  logic [NFLAG-1:0] set_vec, clr_vec, force_vec;
  logic [NFLAG-1:0] flag_q, flag_nx;
  logic             stat_rd;
  logic             irq_q;

  spi_stat_decode #(.NF(NFLAG)) u_dec (
    .reg_sel     (reg_sel),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .xfer_busy   (xfer_busy),
    .xfer_done   (xfer_done),
    .ss_level    (ss_level),
    .master_mode (master_mode),
    .ss_pin_out  (ss_pin_out),
    .set_vec     (set_vec),
    .clr_vec     (clr_vec),
    .force_vec   (force_vec),
    .stat_rd     (stat_rd),
    .wr_blocked  (data_wr_blocked)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    spi_stat_flag_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .set_ev    (set_vec[g]),
      .arm_ev    (stat_rd),
      .clr_acc   (clr_vec[g]),
      .force_clr (force_vec[g]),
      .flag_q    (flag_q[g]),
      .flag_nx   (flag_nx[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_en && (flag_nx[F_XFER] || flag_nx[F_MODF]);
  end

  always_comb begin
    stat_rdata           = '0;
    stat_rdata[XFER_BIT] = flag_q[F_XFER];
    stat_rdata[WCOL_BIT] = flag_q[F_WCOL];
    stat_rdata[MODF_BIT] = flag_q[F_MODF];
  end

  assign xfer_flag = flag_q[F_XFER];
  assign wcol_flag = flag_q[F_WCOL];
  assign modf_flag = flag_q[F_MODF];
  assign irq       = irq_q;
endmodule

// File: rtl/spi_status_flags_chk.sv
module spi_status_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] reg_sel,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic       xfer_busy,
  input logic       xfer_done,
  input logic       ss_level,
  input logic       master_mode,
  input logic       ss_pin_out,
  input logic       irq_en,
  input logic       xfer_flag,
  input logic       wcol_flag,
  input logic       modf_flag,
  input logic       data_wr_blocked,
  input logic       irq
);
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (!xfer_flag && !wcol_flag && !modf_flag && !irq));
  a_r3_done_sets: assert property (@(posedge clk) disable iff (rst) xfer_done |=> xfer_flag);
  a_r4_xfer_clear_path: assert property (@(posedge clk) disable iff (rst)
    ($fell(xfer_flag) && !$past(rst)) |-> $past(reg_sel == 2'd1 && (rd_stb || wr_stb)));
  a_r5_block_now: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && reg_sel == 2'd1 && xfer_busy) |-> data_wr_blocked);
  a_r5_wcol_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && reg_sel == 2'd1 && xfer_busy) |=> wcol_flag);
  a_r6_wcol_clear_path: assert property (@(posedge clk) disable iff (rst)
    ($fell(wcol_flag) && !$past(rst)) |-> $past(reg_sel == 2'd1 && (rd_stb || wr_stb)));
  a_r7_modf_sets: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !ss_level && !ss_pin_out) |=> modf_flag);
  a_r8_modf_inhibit: assert property (@(posedge clk) disable iff (rst) ss_pin_out |=> !modf_flag);
  a_r9_modf_clear_path: assert property (@(posedge clk) disable iff (rst)
    ($fell(modf_flag) && !$past(rst)) |-> $past((wr_stb && reg_sel == 2'd2) || ss_pin_out));
  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    (!xfer_flag && !modf_flag) |-> !irq);
  a_r11_irq_needs_en: assert property (@(posedge clk) disable iff (rst) !irq_en |=> !irq);
endmodule

bind spi_status_flags spi_status_flags_chk u_chk (.*);

// File: tb/tb_spi_status_flags.sv
module tb_spi_status_flags;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_sel = 2'd3;
  logic       rd_stb = 1'b0, wr_stb = 1'b0;
  logic       xfer_busy = 1'b0, xfer_done = 1'b0;
  logic       ss_level = 1'b1, master_mode = 1'b0, ss_pin_out = 1'b0;
  logic       irq_en = 1'b1;
  logic [7:0] stat_rdata;
  logic       xfer_flag, wcol_flag, modf_flag, data_wr_blocked, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_status_flags dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .xfer_busy(xfer_busy), .xfer_done(xfer_done), .ss_level(ss_level),
    .master_mode(master_mode), .ss_pin_out(ss_pin_out), .irq_en(irq_en),
    .stat_rdata(stat_rdata), .xfer_flag(xfer_flag), .wcol_flag(wcol_flag),
    .modf_flag(modf_flag), .data_wr_blocked(data_wr_blocked), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; reg_sel = 2'd3; rd_stb = 0; wr_stb = 0;
    xfer_busy = 0; xfer_done = 0; ss_level = 1; master_mode = 0; ss_pin_out = 0;
    irq_en = 1;
    tick();
    rst = 1'b0;
  endtask

  // kind: 0 data read, 1 data write, 2 ctrl1 write, 3 status read
  task automatic drive_acc(input int kind);
    case (kind)
      0: begin reg_sel = 2'd1; rd_stb = 1; end
      1: begin reg_sel = 2'd1; wr_stb = 1; end
      2: begin reg_sel = 2'd2; wr_stb = 1; end
      default: begin reg_sel = 2'd0; rd_stb = 1; end
    endcase
  endtask

  task automatic idle_bus();
    reg_sel = 2'd3; rd_stb = 0; wr_stb = 0;
  endtask

  task automatic stat_read();
    drive_acc(3); tick(); idle_bus();
  endtask

  initial begin
    logic e;
    tick(); tick();
    // R1
    chk("R1 flags", {5'd0, xfer_flag, wcol_flag, modf_flag}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rdata", stat_rdata, 8'h00);
    rst = 0;

    // R3 R4 R10 R11: transfer flag sweep
    for (int pre = 0; pre < 2; pre++)
      for (int k = 0; k < 4; k++)
        for (int co = 0; co < 2; co++) begin
          do_reset();
          xfer_done = 1; tick(); xfer_done = 0;
          chk("R3 set", {7'd0, xfer_flag}, 8'h01);
          if (pre == 1) stat_read();
          drive_acc(k); xfer_done = co[0]; tick(); idle_bus(); xfer_done = 0;
          e = (co == 1) || !(pre == 1 && k <= 1);
          chk(co ? "R10 xfer keep" : "R4 xfer clear", {7'd0, xfer_flag}, {7'd0, e});
          chk("R11 irq", {7'd0, irq}, {7'd0, e});
          chk("R2 rdata", stat_rdata, {e, 7'd0});
        end

    // R5 R6 R10: collision sweep
    for (int pre = 0; pre < 2; pre++)
      for (int k = 0; k < 4; k++)
        for (int b = 0; b < 2; b++) begin
          do_reset();
          xfer_busy = 1; drive_acc(1); #1;
          chk("R5 blocked", {7'd0, data_wr_blocked}, 8'h01);
          tick(); idle_bus(); xfer_busy = 0; #1;
          chk("R5 no block idle", {7'd0, data_wr_blocked}, 8'h00);
          chk("R5 wcol set", {7'd0, wcol_flag}, 8'h01);
          chk("R6 no irq", {7'd0, irq}, 8'h00);
          if (pre == 1) stat_read();
          xfer_busy = b[0]; drive_acc(k); tick(); idle_bus(); xfer_busy = 0;
          e = (b == 1 && k == 1) || !(pre == 1 && k <= 1);
          chk("R6 wcol clear", {7'd0, wcol_flag}, {7'd0, e});
          chk("R6 rdata", stat_rdata, {1'b0, e, 6'd0});
        end

    // R7 R9 R10: mode fault sweep
    for (int pre = 0; pre < 2; pre++)
      for (int k = 0; k < 4; k++)
        for (int f = 0; f < 2; f++) begin
          do_reset();
          master_mode = 1; ss_level = 0; tick(); ss_level = 1;
          chk("R7 modf set", {7'd0, modf_flag}, 8'h01);
          if (pre == 1) stat_read();
          ss_level = !f[0]; drive_acc(k); tick(); idle_bus(); ss_level = 1;
          e = (f == 1) || !(pre == 1 && k == 2);
          chk("R9 modf clear", {7'd0, modf_flag}, {7'd0, e});
          chk("R11 irq modf", {7'd0, irq}, {7'd0, e});
          chk("R2 rdata modf", stat_rdata, {3'd0, e, 4'd0});
        end

    // R9: read of ctrl1 does not clear
    do_reset();
    master_mode = 1; ss_level = 0; tick(); ss_level = 1;
    stat_read();
    reg_sel = 2'd2; rd_stb = 1; tick(); idle_bus();
    chk("R9 ctrl1 read", {7'd0, modf_flag}, 8'h01);

    // R4: status read with flag at 0 does not arm
    do_reset();
    stat_read();
    xfer_done = 1; tick(); xfer_done = 0;
    drive_acc(0); tick(); idle_bus();
    chk("R4 no arm at 0", {7'd0, xfer_flag}, 8'h01);

    // R8: pin as output inhibits and clears
    do_reset();
    master_mode = 1; ss_pin_out = 1; ss_level = 0; tick();
    chk("R8 inhibit", {7'd0, modf_flag}, 8'h00);
    ss_pin_out = 0; tick();
    chk("R8 detect back", {7'd0, modf_flag}, 8'h01);
    stat_read();
    ss_level = 1; ss_pin_out = 1; tick(); ss_pin_out = 0;
    chk("R8 forced clear", {7'd0, modf_flag}, 8'h00);
    master_mode = 1; ss_level = 0; tick(); ss_level = 1;
    drive_acc(2); tick(); idle_bus();
    chk("R8 arm dropped", {7'd0, modf_flag}, 8'h01);

    // R2: all flags, status write ignored
    do_reset();
    xfer_done = 1; master_mode = 1; ss_level = 0; xfer_busy = 1; drive_acc(1);
    tick(); idle_bus(); xfer_done = 0; ss_level = 1; xfer_busy = 0;
    chk("R2 all set", stat_rdata, 8'hD0);
    stat_read();
    reg_sel = 2'd0; wr_stb = 1; tick(); idle_bus();
    chk("R2 status write", stat_rdata, 8'hD0);

    // R11: enable low
    irq_en = 0; tick();
    chk("R11 irq off", {7'd0, irq}, 8'h00);
    irq_en = 1; tick();
    chk("R11 irq on", {7'd0, irq}, 8'h01);

    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule